// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block turns frames on an idle-high serial line into data words. Each completed frame yields one word on `rx_data` together with a single-cycle `rx_valid` strobe and two error flags, one for a parity mismatch and one for a stop bit that was sampled low. The frame format is not fixed at build time. A packed 32-bit setup word, driven by surrounding logic, sets the bit period in clock cycles, the word length (5 to 8 bits), one or two stop bits, and the parity scheme (none, even, odd, or a fixed level).

The line first passes through a two-flop synchroniser. A falling edge on the synchronised line starts a frame. The setup word is captured at that moment and held until the frame ends, so software may rewrite it at any time without corrupting a frame that is already in progress. The first data bit is sampled one and a half bit periods after the detected edge, which places it near the middle of that bit. Each later bit is sampled one bit period after the previous one.

Top module: `serial_rx_cfg`

## Requirements
- R1: After reset, `rx_valid`, `rx_parity_err` and `rx_frame_err` are low and `rx_data` is zero.
- R2: Setup bits [23:0] give the bit period P in clock cycles. The first data sample falls 1.5·P cycles after the detected start edge, and every later sample falls P cycles after the one before.
- R3: Setup bits [29:28] hold N, and the word has 8−N data bits, received least significant bit first. The word is right-aligned in `rx_data` and every bit above the word length reads zero.
- R4: Setup bit 26 set inserts a parity bit after the data bits. With bit 25 clear, bit 24 set selects even parity (the data bits plus the parity bit hold an even number of ones) and bit 24 clear selects odd parity.
- R5: With bits 26 and 25 both set, the expected parity bit is the fixed level given by setup bit 24, whatever the data.
- R6: `rx_parity_err` is high with the strobe when the received parity bit differs from the expected one. It is never high when parity is disabled.
- R7: Setup bit 27 set selects two stop bits and clear selects one. `rx_frame_err` is high with the strobe when any stop sample is low.
- R8: `rx_valid` is high for exactly one cycle per frame, after the last stop sample. Both error flags are low whenever `rx_valid` is low.
- R9: A change to the setup word while a frame is in progress does not affect that frame. The setup word is captured only when a start edge is accepted while idle.
- R10: A new frame starts only on a high-to-low transition of the synchronised line. A line that stays low after a frame ends produces no further words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Asynchronous serial input, high when idle |
| setup | input | 32 | Packed frame format and bit period |
| rx_valid | output | 1 | One-cycle strobe marking a received word |
| rx_data | output | 8 | Received word, right-aligned |
| rx_parity_err | output | 1 | Parity mismatch, valid with the strobe |
| rx_frame_err | output | 1 | A stop bit was sampled low, valid with the strobe |

## Verification
The hardest case to reach from the ports is a setup change in the middle of a frame. The bench starts a frame under one format and, one bit period after the start bit, switches the setup word to a shorter word length and a different period. It then expects the word that the original format implies. The second hard case is a line that stays low after a bad stop bit. The bench holds the line low for several periods before releasing it, and the scoreboard rejects any extra word that appears.

// File: rtl/serial_rx_cfg.sv
module serial_rx_cfg #(
  parameter int CNT_W = 25
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_line,
  input  logic [31:0] setup,
  output logic        rx_valid,
  output logic [7:0]  rx_data,
  output logic        rx_parity_err,
  output logic        rx_frame_err
);
  localparam int PER_W = 24;

  logic [2:0]       sync_q;
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [3:0]       idx_q;
  logic [31:0]      cfg_q;
  logic [7:0]       word_q;
  logic             par_acc_q, perr_q, ferr_q;

  wire line_s  = sync_q[1];
  wire fall    = !sync_q[1] && sync_q[2];
  wire [3:0] nbits   = 4'd8 - {2'b00, cfg_q[29:28]};
  wire       par_en  = cfg_q[26];
  wire       stick   = cfg_q[25];
  wire       even    = cfg_q[24];
  wire [3:0] total   = nbits + {3'b0, par_en} + {3'b0, cfg_q[27]} + 4'd1;
  wire [CNT_W-1:0] per_now  = CNT_W'(setup[PER_W-1:0]);
  wire [CNT_W-1:0] per_cfg  = CNT_W'(cfg_q[PER_W-1:0]);
  wire [CNT_W-1:0] first_ld = per_now + (per_now >> 1) - 1'b1;
  wire sample  = busy_q && (cnt_q == '0);
  wire is_data = idx_q < nbits;
  wire is_par  = par_en && (idx_q == nbits);
  wire exp_par = stick ? even : (even ? par_acc_q : !par_acc_q);
  wire last    = idx_q == total - 4'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 3'b111;
    else        sync_q <= {sync_q[1:0], rx_line};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q        <= 1'b0;
      cnt_q         <= '0;
      idx_q         <= '0;
      cfg_q         <= '0;
      word_q        <= '0;
      par_acc_q     <= 1'b0;
      perr_q        <= 1'b0;
      ferr_q        <= 1'b0;
      rx_valid      <= 1'b0;
      rx_data       <= '0;
      rx_parity_err <= 1'b0;
      rx_frame_err  <= 1'b0;
    end else begin
      rx_valid      <= 1'b0;
      rx_parity_err <= 1'b0;
      rx_frame_err  <= 1'b0;
      if (!busy_q) begin
        if (fall) begin
          busy_q    <= 1'b1;
          cfg_q     <= setup;
          cnt_q     <= first_ld;
          idx_q     <= '0;
          word_q    <= '0;
          par_acc_q <= 1'b0;
          perr_q    <= 1'b0;
          ferr_q    <= 1'b0;
        end
      end else if (!sample) begin
        cnt_q <= cnt_q - 1'b1;
      end else begin
        cnt_q <= per_cfg - 1'b1;
        idx_q <= idx_q + 4'd1;
        if (is_data) begin
          word_q[idx_q[2:0]] <= line_s;
          par_acc_q          <= par_acc_q ^ line_s;
        end else if (is_par) begin
          perr_q <= line_s != exp_par;
        end else begin
          ferr_q <= ferr_q | !line_s;
        end
        if (last) begin
          busy_q        <= 1'b0;
          rx_valid      <= 1'b1;
          rx_data       <= word_q;
          rx_parity_err <= perr_q;
          rx_frame_err  <= ferr_q | !line_s;
        end
      end
    end
  end

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  a_r8_flags_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> !(rx_parity_err || rx_frame_err));
  a_r3_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ((rx_data >> nbits) == 8'd0));
  a_r6_no_perr_unparity: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !par_en) |-> !rx_parity_err);
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(cfg_q));
  a_r2_strobe_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> ($past(busy_q) && !busy_q));
endmodule

// File: tb/serial_rx_cfg_tb.sv
module serial_rx_cfg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_line = 1'b1;
  logic [31:0] setup = '0;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        rx_parity_err, rx_frame_err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit prev_valid = 1'b0;

  logic [9:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_rx_cfg dut_i (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .setup(setup),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err)
  );

  function automatic logic [31:0] mk_setup(int p, int nb, bit two, bit par, bit stk, bit ev);
    logic [1:0] n = 2'(8 - nb);
    return {2'b00, n, two, par, stk, ev, 24'(p)};
  endfunction

  task automatic wait_bit(int p);
    repeat (p) @(negedge clk);
  endtask

  task automatic send(int p, int nb, bit two, bit par, bit stk, bit ev,
                      logic [7:0] d, bit bad_par, bit bad_stop, int hold_low,
                      bit mid, logic [31:0] alt, string tag);
    logic [7:0] dm;
    logic pb;
    dm = d & 8'((1 << nb) - 1);
    pb = stk ? ev : (ev ? ^dm : ~^dm);
    if (bad_par) pb = ~pb;
    exp_q.push_back({par && bad_par, bad_stop, dm});
    tag_q.push_back(tag);
    setup = mk_setup(p, nb, two, par, stk, ev);
    wait_bit(p);
    rx_line = 1'b0;
    wait_bit(p);
    if (mid) setup = alt;
    for (int i = 0; i < nb; i++) begin
      rx_line = dm[i];
      wait_bit(p);
    end
    if (par) begin
      rx_line = pb;
      wait_bit(p);
    end
    rx_line = !bad_stop;
    wait_bit(p);
    if (two) begin
      rx_line = 1'b1;
      wait_bit(p);
    end
    rx_line = 1'b0;
    if (hold_low > 0) wait_bit(hold_low * p);
    rx_line = 1'b1;
    wait_bit(2 * p);
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rx_valid && prev_valid) begin
        checks++; errors++;
        $display("FAIL R8 strobe longer than one cycle: actual 1 expected 0");
      end
      if (!rx_valid && (rx_parity_err || rx_frame_err)) begin
        checks++; errors++;
        $display("FAIL R8 flags outside strobe: actual %b%b expected 00", rx_parity_err, rx_frame_err);
      end
      if (rx_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R10 unexpected word: actual %h expected none", rx_data);
        end else begin
          logic [9:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if ({rx_parity_err, rx_frame_err, rx_data} !== e) begin
            errors++;
            $display("FAIL %s perr/ferr/data: actual %b %b %h expected %b %b %h",
                     t, rx_parity_err, rx_frame_err, rx_data, e[9], e[8], e[7:0]);
          end
        end
      end
      prev_valid = rx_valid;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk_reset(string what, logic [7:0] a, logic [7:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL R1 %s: actual %h expected %h", what, a, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_reset("rx_valid", {7'b0, rx_valid}, 8'h00);
    chk_reset("rx_data", rx_data, 8'h00);
    chk_reset("rx_parity_err", {7'b0, rx_parity_err}, 8'h00);
    chk_reset("rx_frame_err", {7'b0, rx_frame_err}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R2 R3 plain 8-bit frames at different periods
    send(16, 8, 0, 0, 0, 0, 8'hA5, 0, 0, 0, 0, '0, "R2");
    send(9,  8, 0, 0, 0, 0, 8'h3C, 0, 0, 0, 0, '0, "R2");
    // R3 short words, upper bits cleared
    send(12, 5, 0, 0, 0, 0, 8'hFF, 0, 0, 0, 0, '0, "R3");
    send(12, 7, 0, 0, 0, 0, 8'hD3, 0, 0, 0, 0, '0, "R3");
    send(10, 6, 0, 0, 0, 0, 8'h2A, 0, 0, 0, 0, '0, "R3");
    // R4 even and odd parity
    send(12, 8, 0, 1, 0, 1, 8'h07, 0, 0, 0, 0, '0, "R4");
    send(12, 8, 0, 1, 0, 0, 8'h07, 0, 0, 0, 0, '0, "R4");
    send(12, 7, 0, 1, 0, 1, 8'h41, 0, 0, 0, 0, '0, "R4");
    // R6 wrong parity bit
    send(12, 8, 0, 1, 0, 1, 8'h5A, 1, 0, 0, 0, '0, "R6");
    send(12, 5, 0, 1, 0, 0, 8'h13, 1, 0, 0, 0, '0, "R6");
    // R5 fixed parity level
    send(12, 8, 0, 1, 1, 1, 8'h00, 0, 0, 0, 0, '0, "R5");
    send(12, 8, 0, 1, 1, 0, 8'hFF, 0, 0, 0, 0, '0, "R5");
    send(12, 8, 0, 1, 1, 1, 8'h81, 1, 0, 0, 0, '0, "R5");
    // R7 stop bits and framing error
    send(12, 8, 1, 0, 0, 0, 8'h96, 0, 0, 0, 0, '0, "R7");
    send(12, 8, 1, 1, 0, 1, 8'h69, 0, 1, 0, 0, '0, "R7");
    send(12, 8, 0, 0, 0, 0, 8'hC3, 0, 1, 0, 0, '0, "R7");
    // R10 line held low after a bad stop, then a clean frame
    send(12, 8, 0, 0, 0, 0, 8'h55, 0, 1, 3, 0, '0, "R10");
    send(12, 8, 0, 0, 0, 0, 8'hAA, 0, 0, 0, 0, '0, "R10");
    // R9 setup rewritten mid-frame
    send(16, 8, 0, 1, 0, 1, 8'hE7, 0, 0, 0, 1, mk_setup(9, 5, 1, 0, 0, 0), "R9");
    send(10, 5, 0, 0, 0, 0, 8'h1E, 0, 0, 0, 0, '0, "R9");
    wait_bit(40);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R10 missing words: actual %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule